// File: doc/BRIEF.md
# Iterative Half-Adder Binary Adder

This block adds two unsigned WIDTH-bit operands without a carry-propagate chain. Every bit position has one half-adder and one two-input multiplexer. When a start is accepted, the multiplexers pass the external operands and each bit captures its half-sum and the carry it generates. After that the multiplexers switch to the fed-back sum vector and the carry vector moved up by one bit. The half-adders are applied again on each clock until no carry remains.

The latency therefore depends on the data. It is one cycle when no bit position holds two ones, and it reaches WIDTH+1 cycles when a carry must ripple across the whole word. A completion flag marks the end of the addition. The flag holds the sum and the carry-out until the next start is accepted, so a caller only needs to pulse start and wait for done.

Top module: `hsa_iter_adder`

## Requirements
- R1: While reset is high and after it is released, done, sum and cout are all 0 until a start is accepted.
- R2: A start is accepted when no addition is iterating, which includes the state where done is high. done is 0 in the cycle after the accepting clock edge.
- R3: When done rises, {cout, sum} equals opa + opb as an unsigned (WIDTH+1)-bit value, where opa and opb are the operands present at the accepting edge.
- R4: If opa & opb is zero, no iteration is needed and done is high after the first clock edge that follows the accepting edge.
- R5: The number of iterations never exceeds WIDTH, so done rises no later than WIDTH+1 edges after the accepting edge. All-ones plus one needs exactly WIDTH iterations (done after WIDTH+1 edges), and all-ones plus all-ones needs exactly one (done after 2 edges).
- R6: Once high, done stays high and sum and cout stay constant until the next start is accepted.
- R7: A start that arrives while an addition is iterating is ignored. The running addition keeps its operands, its result and its latency.
- R8: cout is sticky for one addition: it is set by a carry out of bit WIDTH-1 on any step and is cleared when a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an addition |
| opa | input | WIDTH | First operand, sampled at the accepting edge |
| opb | input | WIDTH | Second operand, sampled at the accepting edge |
| sum | output | WIDTH | Sum vector; final when done is high |
| cout | output | 1 | Carry out of the most significant bit |
| done | output | 1 | Completion flag, held until the next accepted start |

## Verification
The bench builds the adder with WIDTH = 8. At that width the longest carry ripple costs only nine cycles, so the exact latency of the worst-case and no-carry patterns can be checked one cycle at a time. The narrow word also lets a few dozen random operand pairs cover many mixes of short and long carry runs. Restart from the done state, a start arriving mid-iteration, and a carry out of the top bit followed by a carry-free addition are each driven as separate scenarios.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } hsa_phase_e;

    typedef struct packed {
        logic s;
        logic c;
    } ha_out_t;

    function automatic ha_out_t half_add(input logic x, input logic y);
        ha_out_t r;
        r.s = x ^ y;
        r.c = x & y;
        return r;
    endfunction

endpackage

// File: rtl/hsa_bit_cell.sv
module hsa_bit_cell
    import hsa_pkg::*;
(
    input  logic sel,
    input  logic op_a,
    input  logic op_b,
    input  logic fb_sum,
    input  logic fb_carry,
    output logic sum_nx,
    output logic carry_nx
);
    logic    x_in;
    logic    y_in;
    ha_out_t res;

    always_comb begin
        x_in     = sel ? fb_sum   : op_a;
        y_in     = sel ? fb_carry : op_b;
        res      = half_add(x_in, y_in);
        sum_nx   = res.s;
        carry_nx = res.c;
    end
endmodule

// File: rtl/hsa_zero_detect.sv
module hsa_zero_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] vec,
    output logic             all_zero
);
    assign all_zero = ~(|vec);
endmodule

// File: rtl/hsa_ctrl.sv
module hsa_ctrl
    import hsa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       carries_zero,
    output hsa_phase_e phase,
    output logic       sel,
    output logic       load_en,
    output logic       step_en,
    output logic       done
);
    hsa_phase_e phase_q;

    always_comb begin
        sel     = (phase_q == PH_RUN);
        load_en = start && (phase_q != PH_RUN);
        step_en = (phase_q == PH_RUN) && !carries_zero;
        done    = (phase_q == PH_FIN) && !sel;
        phase   = phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else if (load_en) begin
            phase_q <= PH_RUN;
        end else if ((phase_q == PH_RUN) && carries_zero) begin
            phase_q <= PH_FIN;
        end
    end
endmodule

// File: rtl/hsa_iter_adder.sv
module hsa_iter_adder
    import hsa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             done
);
    localparam int MSB = WIDTH - 1;

    hsa_phase_e       phase;
    logic             sel;
    logic             load_en;
    logic             step_en;
    logic             carries_zero;
    logic             running;
    logic [WIDTH-1:0] s_q;
    logic [WIDTH-1:0] cy_q;
    logic [WIDTH-1:0] cin_fb;
    logic [WIDTH-1:0] s_nx;
    logic [WIDTH-1:0] c_nx;
    logic             sticky_q;

    // carry into bit i is the carry out of bit i-1; bit 0 receives none
    assign cin_fb  = {cy_q[MSB-1:0], 1'b0};
    assign running = (phase == PH_RUN);

    hsa_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .carries_zero (carries_zero),
        .phase        (phase),
        .sel          (sel),
        .load_en      (load_en),
        .step_en      (step_en),
        .done         (done)
    );

    hsa_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .vec      (cy_q),
        .all_zero (carries_zero)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        hsa_bit_cell u_cell (
            .sel      (sel),
            .op_a     (opa[i]),
            .op_b     (opb[i]),
            .fb_sum   (s_q[i]),
            .fb_carry (cin_fb[i]),
            .sum_nx   (s_nx[i]),
            .carry_nx (c_nx[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            cy_q     <= '0;
            sticky_q <= 1'b0;
        end else if (load_en || step_en) begin
            s_q      <= s_nx;
            cy_q     <= c_nx;
            sticky_q <= load_en ? c_nx[MSB] : (sticky_q | c_nx[MSB]);
        end
    end

    assign sum  = s_q;
    assign cout = sticky_q;
endmodule

// File: rtl/hsa_iter_adder_chk.sv
module hsa_iter_adder_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             done,
    input logic             running,
    input logic [WIDTH-1:0] s_q,
    input logic [WIDTH-1:0] cy_q
);
    localparam int CW = $clog2(WIDTH + 2) + 1;

    logic             accept;
    logic [WIDTH-1:0] a_l;
    logic [WIDTH-1:0] b_l;
    logic [CW-1:0]    steps;

    assign accept = start && !running;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_l   <= '0;
            b_l   <= '0;
            steps <= '0;
        end else if (accept) begin
            a_l   <= opa;
            b_l   <= opb;
            steps <= '0;
        end else if (running && (cy_q != '0)) begin
            steps <= steps + 1'b1;
        end
    end

    // R3
    result_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ({cout, sum} == ({1'b0, a_l} + {1'b0, b_l})));

    // R3
    no_double_one_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q & cy_q) == '0);

    // R5
    iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
        steps <= CW'(WIDTH));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(sum) && $stable(cout)));

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !done);

    // R8
    sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (cout == ($past(opa[WIDTH-1]) & $past(opb[WIDTH-1]))));
endmodule

bind hsa_iter_adder hsa_iter_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .opa     (opa),
    .opb     (opb),
    .sum     (sum),
    .cout    (cout),
    .done    (done),
    .running (running),
    .s_q     (s_q),
    .cy_q    (cy_q)
);

// File: tb/test_hsa_iter_adder.sv
module test_hsa_iter_adder;
    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] sum;
    logic         cout;
    logic         done;

    int total = 0;
    int bad   = 0;
    logic [W:0] exp_q[$];
    logic       done_d = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsa_iter_adder #(.WIDTH(W)) i_hsa_iter_adder (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .opa   (opa),
        .opb   (opb),
        .sum   (sum),
        .cout  (cout),
        .done  (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: result checked on each rising edge of done (R3)
    always @(negedge clk) begin
        if (!rst) begin
            if (done && !done_d) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected completion", int'({cout, sum}), -1);
                end else begin
                    logic [W:0] e;
                    e = exp_q.pop_front();
                    chk({cout, sum} == e, "R3", "sum with carry", int'({cout, sum}), int'(e));
                end
            end
            done_d = done;
        end
    end

    // driver: pulse start, queue expected result, measure latency
    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b,
                           input int exp_lat, input string req,
                           input bit poke_mid);
        int lat;
        @(negedge clk);
        opa   = a;
        opb   = b;
        start = 1'b1;
        exp_q.push_back({1'b0, a} + {1'b0, b});
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R2", "done low after accept", int'(done), 0);
        lat = 0;
        while (!done && lat < W + 4) begin
            if (poke_mid && lat == 1) begin
                opa   = '0;
                opb   = '0;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(lat <= W + 1, "R5", "latency bound", lat, W + 1);
        if (exp_lat > 0)
            chk(lat == exp_lat, req, "exact latency", lat, exp_lat);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(done == 1'b0 && sum == '0 && cout == 1'b0, "R1", "reset outputs",
            int'({done, cout, sum}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && sum == '0 && cout == 1'b0, "R1", "idle after reset",
            int'({done, cout, sum}), 0);

        // R4 no generated carries
        run_add(8'h55, 8'hAA, 1, "R4", 1'b0);
        run_add(8'h00, 8'h00, 1, "R4", 1'b0);
        run_add(8'hF0, 8'h0F, 1, "R4", 1'b0);

        // R5 worst ripple and one-step case
        run_add(8'hFF, 8'h01, W + 1, "R5", 1'b0);
        run_add(8'hFF, 8'hFF, 2, "R5", 1'b0);

        // R6 hold after completion
        held = sum;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(done == 1'b1 && sum == held, "R6", "done and sum held",
                int'({done, sum}), int'({1'b1, held}));
        end

        // R7 start mid-iteration ignored (result and latency unchanged)
        run_add(8'hFF, 8'h01, W + 1, "R7", 1'b1);
        chk(sum == 8'h00 && cout == 1'b1, "R7", "original result kept",
            int'({cout, sum}), 9'h100);

        // R8 sticky carry out, then cleared by new start
        run_add(8'h80, 8'h80, 2, "R8", 1'b0);
        chk(cout == 1'b1, "R8", "carry out set", int'(cout), 1);
        run_add(8'h01, 8'h02, 1, "R8", 1'b0);
        chk(cout == 1'b0, "R8", "carry out cleared", int'(cout), 0);

        // R3 random operands (R2 restart from done each time)
        for (int n = 0; n < 60; n++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = W'($urandom);
            rb = W'($urandom);
            run_add(ra, rb, -1, "R3", 1'b0);
        end

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "all results seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule